// File: doc/BRIEF.md
# Reset Strap Capture and PHY Configuration

This block latches the levels on a group of shared multifunction pins during hardware reset and turns them into the power-up configuration of an Ethernet PHY. The configuration covers the station address, the isolate flag, the auto-negotiation ability bits, the duplex default for the basic control register, the MAC interface mode (MII or RMII), the LED mode and the auto-MDIX enable. The pins are used for other functions once reset is released. For that reason the block samples them only while reset is low and freezes the result at the clock edge where reset goes high.

Every strap pin first passes through a two-flop synchronizer. A small write port then lets software replace the address, the LED mode and the MDIX enable. An override lasts until the next hardware reset. The isolate flag is not writable: it follows only the strapped address. The reset is synchronous and active low.

Top module: `rst_strap_cfg`

## Requirements
- R1: After reset is released, `phy_addr` equals the 5-bit value that the address strap pins held during reset. All values from 0 to 31 are allowed.
- R2: `isolate` is 1 exactly when the strapped address is 0.
- R3: A write with `wr_sel`=0 loads `wr_data[4:0]` into `phy_addr`, visible one cycle after the write edge. A write never changes `isolate`, even when it writes address 0.
- R4: `adv_abil` has bit0=10M half, bit1=10M full, bit2=100M half and bit3=100M full. An auto-negotiation strap of 0 gives 4'b0101 and a strap of 1 gives 4'b1111. `bmc_fdx` equals the strap.
- R5: `rmii_mode` equals the interface-mode strap: 0 selects MII and 1 selects RMII.
- R6: An LED strap of 1 gives `led_mode`=2'd1 (mode 1). An LED strap of 0 gives `led_mode`=2'd2 (mode 2).
- R7: A write with `wr_sel`=1 loads `wr_data[1:0]` into `led_mode` one cycle later. This includes mode 3.
- R8: `mdix_en` equals the MDIX strap, where a low pin disables auto-MDIX. A write with `wr_sel`=2 loads `wr_data[0]` one cycle later.
- R9: After release, pin changes have no effect on any output until the next reset. A write with `wr_sel`=3 changes nothing.
- R10: Reset clears all software overrides. Writes made while reset is low are ignored.
- R11: The captured value is the one the pins held at the clock edge two edges before the last edge with reset low. A change made after that edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| pin_addr | input | 5 | Address strap pins |
| pin_an | input | 1 | Auto-negotiation ability strap |
| pin_ifmode | input | 1 | MAC interface mode strap |
| pin_led | input | 1 | LED mode strap |
| pin_mdix | input | 1 | Auto-MDIX enable strap |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Field select: 0 address, 1 LED, 2 MDIX, 3 none |
| wr_data | input | 5 | Write data |
| phy_addr | output | 5 | Active PHY address |
| isolate | output | 1 | MII isolate, from the strap only |
| adv_abil | output | 4 | Advertised abilities |
| bmc_fdx | output | 1 | Full-duplex default for the basic control register |
| rmii_mode | output | 1 | 1 = RMII, 0 = MII |
| led_mode | output | 2 | LED mode |
| mdix_en | output | 1 | Auto-MDIX enable |

## Verification
The bench straps address 0 and then writes a nonzero address, and it also straps a nonzero address and writes 0. A design that derives isolate from the live address field would flip `isolate` in one of these two cases. It toggles the pins after release and in the final reset cycles. A capture that is not frozen, or that skips the synchronizer, then shows the wrong strap value. It also writes during reset and writes with the unused select, which exposes a design that lets those writes through or keeps an override across reset.

// File: rtl/strap_pkg.sv
`timescale 1ns/1ps
// Package: widths, the strap bundle type and the write field codes shared by the strap logic.
package strap_pkg;
    localparam int ADDR_W = 5;
    localparam int LED_W  = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              an;
        logic              ifmode;
        logic              led;
        logic              mdix;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_LED  = 2'd1,
        FLD_MDIX = 2'd2,
        FLD_NONE = 2'd3
    } wr_fld_e;

    localparam logic [LED_W-1:0] LED_MODE1 = 2'd1;
    localparam logic [LED_W-1:0] LED_MODE2 = 2'd2;
endpackage

// File: rtl/strap_sync.sv
`timescale 1ns/1ps
// Module: strap_sync
// A multi-stage synchronizer for a vector of slow pin levels.
// Assumes the pins are quasi-static, so each bit is synchronized on its own.
// There is no reset: the chain must keep sampling while reset is held.
module strap_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    // First stage samples the asynchronous pins.
    always_ff @(posedge clk) stg[0] <= din;

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage resolves metastability from the stage before it.
            always_ff @(posedge clk) stg[s] <= stg[s-1];
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
// Module: strap_capture
// Tracks the synchronized strap levels while reset is low.
// Holds the last tracked value once reset is released.
// Assumes rst_n is synchronous to clk.
module strap_capture
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  strap_t sync_in,
    output strap_t strap_q
);
    // Load while in reset; freeze from the first edge with reset high.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= sync_in;
    end
endmodule

// File: rtl/cfg_override.sv
`timescale 1ns/1ps
// Module: cfg_override
// Software overrides for the address, LED mode and MDIX fields.
// Each field shows its strap-derived default until a write replaces it.
// Reset clears every override, and writes during reset are dropped.
module cfg_override
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dflt_addr,
    input  logic [LED_W-1:0]  dflt_led,
    input  logic              dflt_mdix,
    input  logic              wr_en,
    input  wr_fld_e           wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LED_W-1:0]  led_o,
    output logic              mdix_o
);
    logic              addr_vld, led_vld, mdix_vld;
    logic [ADDR_W-1:0] addr_ovr;
    logic [LED_W-1:0]  led_ovr;
    logic              mdix_ovr;

    // Record software writes; hardware reset drops all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_vld <= 1'b0;
            led_vld  <= 1'b0;
            mdix_vld <= 1'b0;
            addr_ovr <= '0;
            led_ovr  <= '0;
            mdix_ovr <= 1'b0;
        end else if (wr_en) begin
            case (wr_fld)
                FLD_ADDR: begin addr_vld <= 1'b1; addr_ovr <= wr_data; end
                FLD_LED:  begin led_vld  <= 1'b1; led_ovr  <= wr_data[LED_W-1:0]; end
                FLD_MDIX: begin mdix_vld <= 1'b1; mdix_ovr <= wr_data[0]; end
                default:  ;
            endcase
        end
    end

    // Choose the override when one exists, otherwise the strap default.
    always_comb begin
        addr_o = addr_vld ? addr_ovr : dflt_addr;
        led_o  = led_vld  ? led_ovr  : dflt_led;
        mdix_o = mdix_vld ? mdix_ovr : dflt_mdix;
    end
endmodule

// File: rtl/rst_strap_cfg.sv
`timescale 1ns/1ps
// Module: rst_strap_cfg
// Reset strap capture and PHY configuration.
// The pins are synchronized, captured during reset and frozen at its release.
// The captured straps are decoded into the configuration outputs, and a few
// fields can be overridden by software writes.
// Assumes rst_n is synchronous and low for at least SYNC_STAGES+1 edges.
module rst_strap_cfg
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic              pin_an,
    input  logic              pin_ifmode,
    input  logic              pin_led,
    input  logic              pin_mdix,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              isolate,
    output logic [3:0]        adv_abil,
    output logic              bmc_fdx,
    output logic              rmii_mode,
    output logic [LED_W-1:0]  led_mode,
    output logic              mdix_en
);
    strap_t           pins_raw, pins_sync, strap_q;
    logic [LED_W-1:0] led_dflt;

    // Bundle the raw pins into the strap type.
    always_comb begin
        pins_raw.addr   = pin_addr;
        pins_raw.an     = pin_an;
        pins_raw.ifmode = pin_ifmode;
        pins_raw.led    = pin_led;
        pins_raw.mdix   = pin_mdix;
    end

    strap_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    strap_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (pins_sync),
        .strap_q (strap_q)
    );

    // Decode the captured straps into the fixed configuration outputs.
    always_comb begin
        isolate   = (strap_q.addr == '0);
        adv_abil  = {strap_q.an, 1'b1, strap_q.an, 1'b1};
        bmc_fdx   = strap_q.an;
        rmii_mode = strap_q.ifmode;
        led_dflt  = strap_q.led ? LED_MODE1 : LED_MODE2;
    end

    cfg_override u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .dflt_addr (strap_q.addr),
        .dflt_led  (led_dflt),
        .dflt_mdix (strap_q.mdix),
        .wr_en     (wr_en),
        .wr_fld    (wr_fld_e'(wr_sel)),
        .wr_data   (wr_data),
        .addr_o    (phy_addr),
        .led_o     (led_mode),
        .mdix_o    (mdix_en)
    );
endmodule

// File: rtl/rst_strap_cfg_chk.sv
`timescale 1ns/1ps
// Checker for rst_strap_cfg. It watches only the ports, and it is bound below.
module rst_strap_cfg_chk
    import strap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic [ADDR_W-1:0] phy_addr,
    input logic              isolate,
    input logic [3:0]        adv_abil,
    input logic              bmc_fdx,
    input logic              rmii_mode,
    input logic [LED_W-1:0]  led_mode,
    input logic              mdix_en
);
    p_isolate_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(isolate));

    p_addr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (phy_addr == $past(wr_data)));

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en && wr_sel == 2'd0)) |-> $stable(phy_addr));

    p_half_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (adv_abil[0] && adv_abil[2]));

    p_full_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (adv_abil[1] == adv_abil[3] && adv_abil[1] == bmc_fdx));

    p_ifmode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(rmii_mode));

    p_led_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (led_mode == $past(wr_data[1:0])));

    p_mdix_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (mdix_en == $past(wr_data[0])));
endmodule

bind rst_strap_cfg rst_strap_cfg_chk u_chk (.*);

// File: tb/rst_strap_cfg_tb.sv
`timescale 1ns/1ps
module rst_strap_cfg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pin_addr = 5'd1;
    logic       pin_an = 1'b1, pin_ifmode = 1'b0, pin_led = 1'b1, pin_mdix = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [4:0] wr_data = 5'd0;
    logic [4:0] phy_addr;
    logic       isolate, bmc_fdx, rmii_mode, mdix_en;
    logic [3:0] adv_abil;
    logic [1:0] led_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected state tracked by the bench.
    logic [4:0] e_addr;
    logic       e_iso, e_an, e_if, e_mdix;
    logic [1:0] e_led;

    always #4 clk = ~clk;

    rst_strap_cfg u_dut (.*);

    function automatic logic [3:0] exp_adv(input logic an);
        return an ? 4'b1111 : 4'b0101;
    endfunction

    function automatic logic [1:0] exp_led(input logic led);
        return led ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R1 addr",  phy_addr,  e_addr);
        chk("R2 iso",   isolate,   e_iso);
        chk("R4 adv",   adv_abil,  exp_adv(e_an));
        chk("R4 fdx",   bmc_fdx,   e_an);
        chk("R5 rmii",  rmii_mode, e_if);
        chk("R6 led",   led_mode,  e_led);
        chk("R8 mdix",  mdix_en,   e_mdix);
    endtask

    // Apply reset with the given straps, release it, then scramble the pins.
    task automatic strap_reset(input logic [4:0] a, input logic an, input logic ifm,
                               input logic led, input logic mdx);
        @(negedge clk);
        rst_n = 1'b0;
        pin_addr = a; pin_an = an; pin_ifmode = ifm; pin_led = led; pin_mdix = mdx;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R9: the pins now serve other functions; these levels must not be captured.
        pin_addr = 5'($urandom); pin_an = 1'($urandom); pin_ifmode = 1'($urandom);
        pin_led = 1'($urandom); pin_mdix = 1'($urandom);
        e_addr = a; e_iso = (a == 5'd0); e_an = an; e_if = ifm;
        e_led = exp_led(led); e_mdix = mdx;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: e_addr = d;
            2'd1: e_led = d[1:0];
            2'd2: e_mdix = d[0];
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Pin defaults with no external resistors: AN high, MII, LED mode 1, MDIX on.
        strap_reset(5'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        check_all();

        // R2: a strapped address of 0 selects isolate.
        strap_reset(5'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all();
        // R3: writing a nonzero address must not clear isolate.
        do_write(2'd0, 5'd9);
        chk("R3 addr after write", phy_addr, 5'd9);
        chk("R3 iso kept", isolate, 1'b1);

        // R3: writing address 0 must not set isolate.
        strap_reset(5'd31, 1'b1, 1'b0, 1'b1, 1'b1);
        do_write(2'd0, 5'd0);
        chk("R3 addr zero", phy_addr, 5'd0);
        chk("R3 no iso", isolate, 1'b0);

        // R7: every LED mode can be written, including mode 3.
        do_write(2'd1, 5'd3);
        chk("R7 led3", led_mode, 2'd3);
        // R8: a write disables MDIX.
        do_write(2'd2, 5'd0);
        chk("R8 mdix write", mdix_en, 1'b0);
        // R9: the unused select changes nothing.
        do_write(2'd3, 5'd17);
        check_all();

        // R10: reset clears the overrides and drops writes made during reset.
        @(negedge clk);
        rst_n = 1'b0;
        pin_addr = 5'd12; pin_an = 1'b0; pin_ifmode = 1'b1; pin_led = 1'b0; pin_mdix = 1'b1;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 5'd3;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e_addr = 5'd12; e_iso = 1'b0; e_an = 1'b0; e_if = 1'b1; e_led = 2'd2; e_mdix = 1'b1;
        chk("R10 led after reset", led_mode, 2'd2);
        check_all();

        // R11: a change in the last two reset edges is not captured.
        @(negedge clk);
        rst_n = 1'b0;
        pin_addr = 5'd5; pin_an = 1'b1; pin_ifmode = 1'b0; pin_led = 1'b1; pin_mdix = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        pin_addr = 5'd0; pin_an = 1'b0; pin_ifmode = 1'b1; pin_led = 1'b0; pin_mdix = 1'b1;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e_addr = 5'd5; e_iso = 1'b0; e_an = 1'b1; e_if = 1'b0; e_led = 2'd1; e_mdix = 1'b0;
        chk("R11 late change", phy_addr, 5'd5);
        check_all();

        // Random straps and writes (R1, R4, R5, R6, R7, R8, R9).
        for (int i = 0; i < 40; i++) begin
            strap_reset(5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            check_all();
            for (int j = 0; j < 4; j++) begin
                do_write(2'($urandom), 5'($urandom));
                check_all();
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule